// File: doc/BRIEF.md
# Request-Paced Circular-Buffer DMA Channel

This block is a single DMA channel that keeps a peripheral FIFO fed from memory. A descriptor is loaded first: source and destination addresses, signed per-element offsets, an element size code, a byte count per minor loop, a minor-loop count per major loop, optional modulo windows and end-of-major address adjustments. After that, each pulse on the request input moves one minor loop. Every element is one read from the source address followed by one write of the same data to the destination address.

The source address usually steps forward through a buffer. The destination offset is usually zero, so every write goes to one FIFO data register. When a modulo value is set, only the low address bits may change, and the walk through the buffer wraps inside an aligned power-of-two window. That window is the circular buffer. When the programmed number of minor loops is done, the channel raises a one-cycle interrupt, adds the end-of-major adjustments, reloads its major count and goes on serving requests without further setup.

Top module: `fifo_feed_dma`

## Requirements
- R1: While reset is held and after it is released with no activity, `mem_valid` and `irq` are low.
- R2: Each request produces exactly `nbytes / 2^size` read-write element pairs (one minor loop). No bus access is issued while every request received has already been served.
- R3: An element reads at the current source address (`mem_write`=0), then writes the returned read data unchanged to the current destination address (`mem_write`=1). `mem_size` carries the size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R4: After each element the source address advances by the sign-extended source offset and the destination address by the destination offset. A zero offset keeps the address fixed.
- R5: A modulo value m in 1..31 holds address bits 31..m fixed and lets bits m-1..0 wrap. A value of 0 lets the whole address change.
- R6: When the last element of the last minor loop of a major loop is written, `irq` is high for exactly the next cycle. The signed last-source and last-destination adjustments are then added to the stepped addresses, with no modulo.
- R7: After a major loop completes, the major count reloads and later requests go on from the adjusted addresses.
- R8: Requests that arrive while a minor loop is running are counted (up to 2^PEND_W-1 outstanding) and each one is served exactly once, in turn.
- R9: At most one access is outstanding. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` hold steady.
- R10: A `cfg_load` pulse given while the channel is idle loads the descriptor and restarts both loop counts. The next element reads from the newly loaded source address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load descriptor (idle only) |
| cfg_saddr | input | AW | Initial source address |
| cfg_daddr | input | AW | Initial destination address |
| cfg_soff | input | OW | Signed source offset per element |
| cfg_doff | input | OW | Signed destination offset per element |
| cfg_size | input | 2 | Element size code |
| cfg_smod | input | MODW | Source modulo bit count, 0 = off |
| cfg_dmod | input | MODW | Destination modulo bit count, 0 = off |
| cfg_nbytes | input | NBW | Bytes per minor loop |
| cfg_nmajor | input | MJW | Minor loops per major loop (1 or more) |
| cfg_slast | input | AW | Signed source adjustment at major end |
| cfg_dlast | input | AW | Signed destination adjustment at major end |
| req | input | 1 | Peripheral request pulse, one minor loop each |
| mem_valid | output | 1 | Bus access valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Bus accepts the access / read data valid |
| mem_rdata | input | DW | Read data |
| irq | output | 1 | Major-loop completion pulse |

## Verification
The bench aims at the source wrap at the top of a modulo window, started from the middle of the window. A design that carries into the frozen upper bits would walk out of the buffer instead of returning to its base. It checks negative offsets and a destination window together with end-of-major adjustments, where applying the adjustment on the wrong loop or through the modulo mask shifts every later address. Bursts of requests are sent during a running minor loop with random bus stalls: a design that drops or double-counts a request ends with a mismatch between requests and served loops. A design that lets the address move during a stall breaks the hold check. A one-byte, single-minor-loop major loop checks that the interrupt fires on every request.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } dma_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW   = 32,
  parameter int MODW = $clog2(AW)
) (
  input  logic [AW-1:0]   cur,
  input  logic [AW-1:0]   step,
  input  logic [AW-1:0]   adj,
  input  logic [MODW-1:0] modbits,
  input  logic            apply_adj,
  output logic [AW-1:0]   nxt
);

  logic [AW-1:0] sum;
  logic [AW-1:0] wrap_mask;
  logic [AW-1:0] wrapped;

  assign sum = cur + step;

  // bit i may change when modulo is off or i lies below the modulo bit count
  for (genvar gi = 0; gi < AW; gi++) begin : g_mask
    assign wrap_mask[gi] = (modbits == '0) || (MODW'(gi) < modbits);
  end

  assign wrapped = (cur & ~wrap_mask) | (sum & wrap_mask);
  assign nxt     = apply_adj ? (wrapped + adj) : wrapped;

endmodule

// File: rtl/dma_req_count.sv
module dma_req_count #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic req,
  input  logic take,
  output logic has_req
);

  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] pend_d;
  logic              pend_en;

  always_comb begin
    pend_d = pend_q;
    if (clear) begin
      pend_d = '0;
    end else begin
      if (req)  pend_d = pend_d + PEND_W'(1);
      if (take) pend_d = pend_d - PEND_W'(1);
    end
  end

  assign pend_en = clear | req | take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign has_req = (pend_q != '0);

  AST_PEND_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !take && !clear && (pend_q == {PEND_W{1'b1}}))); // R8

  AST_TAKE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear) |-> has_req); // R8

endmodule

// File: rtl/dma_loop_ctr.sv
module dma_loop_ctr #(
  parameter int NBW = 10,
  parameter int MJW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           elem_done,
  input  logic [NBW-1:0] nbytes,
  input  logic [MJW-1:0] nmajor,
  input  logic [NBW-1:0] elem_bytes,
  output logic           minor_last,
  output logic           major_last
);

  logic [NBW-1:0] bytes_q, bytes_d;
  logic [MJW-1:0] major_q, major_d;
  logic           cnt_en;

  assign minor_last = (bytes_q <= elem_bytes);
  assign major_last = (major_q <= MJW'(1));

  always_comb begin
    bytes_d = bytes_q;
    major_d = major_q;
    if (load) begin
      bytes_d = nbytes;
      major_d = nmajor;
    end else if (elem_done) begin
      if (minor_last) begin
        bytes_d = nbytes;
        major_d = major_last ? nmajor : (major_q - MJW'(1));
      end else begin
        bytes_d = bytes_q - elem_bytes;
      end
    end
  end

  assign cnt_en = load | elem_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      major_q <= '0;
    end else if (cnt_en) begin
      bytes_q <= bytes_d;
      major_q <= major_d;
    end
  end

  AST_MAJOR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done && !load && minor_last && major_last) |=> (major_q == $past(nmajor))); // R7

endmodule

// File: rtl/fifo_feed_dma.sv
module fifo_feed_dma
  import dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int OW     = 16,
  parameter int NBW    = 10,
  parameter int MJW    = 10,
  parameter int PEND_W = 4,
  parameter int MODW   = $clog2(AW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [AW-1:0]   cfg_saddr,
  input  logic [AW-1:0]   cfg_daddr,
  input  logic [OW-1:0]   cfg_soff,
  input  logic [OW-1:0]   cfg_doff,
  input  logic [1:0]      cfg_size,
  input  logic [MODW-1:0] cfg_smod,
  input  logic [MODW-1:0] cfg_dmod,
  input  logic [NBW-1:0]  cfg_nbytes,
  input  logic [MJW-1:0]  cfg_nmajor,
  input  logic [AW-1:0]   cfg_slast,
  input  logic [AW-1:0]   cfg_dlast,
  input  logic            req,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_size,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic            irq
);

  localparam int EXT_W = AW - OW;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // descriptor registers
  logic [AW-1:0]   soff_q, doff_q, slast_q, dlast_q;
  logic [1:0]      size_q;
  logic [MODW-1:0] smod_q, dmod_q;
  logic [NBW-1:0]  nbytes_q;
  logic [MJW-1:0]  nmajor_q;
  logic            desc_ok_q;
  logic            desc_en;

  dma_state_e      st_q, st_d;
  logic [AW-1:0]   saddr_q, saddr_d, daddr_q, daddr_d;
  logic [AW-1:0]   s_step, d_step;
  logic [DW-1:0]   rbuf_q;
  logic            irq_q;

  logic            load_ok;
  logic            elem_done, minor_done, major_done;
  logic            minor_last, major_last;
  logic            has_req;
  logic            addr_en, rbuf_en;
  logic [NBW-1:0]  elem_bytes;

  assign load_ok    = cfg_load && (st_q == ST_IDLE);
  assign desc_en    = load_ok;
  assign elem_done  = (st_q == ST_WRITE) && mem_ready;
  assign minor_done = elem_done && minor_last;
  assign major_done = minor_done && major_last;
  assign elem_bytes = NBW'(1) << size_q;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      soff_q    <= '0;
      doff_q    <= '0;
      slast_q   <= '0;
      dlast_q   <= '0;
      size_q    <= SZ_WORD;
      smod_q    <= '0;
      dmod_q    <= '0;
      nbytes_q  <= '0;
      nmajor_q  <= '0;
      desc_ok_q <= 1'b0;
    end else if (desc_en) begin
      soff_q    <= {{EXT_W{cfg_soff[OW-1]}}, cfg_soff};
      doff_q    <= {{EXT_W{cfg_doff[OW-1]}}, cfg_doff};
      slast_q   <= cfg_slast;
      dlast_q   <= cfg_dlast;
      size_q    <= cfg_size;
      smod_q    <= cfg_smod;
      dmod_q    <= cfg_dmod;
      nbytes_q  <= cfg_nbytes;
      nmajor_q  <= cfg_nmajor;
      desc_ok_q <= 1'b1;
    end
  end

  dma_addr_step #(.AW(AW), .MODW(MODW)) i_src_step (
    .cur      (saddr_q),
    .step     (soff_q),
    .adj      (slast_q),
    .modbits  (smod_q),
    .apply_adj(major_done),
    .nxt      (s_step)
  );

  dma_addr_step #(.AW(AW), .MODW(MODW)) i_dst_step (
    .cur      (daddr_q),
    .step     (doff_q),
    .adj      (dlast_q),
    .modbits  (dmod_q),
    .apply_adj(major_done),
    .nxt      (d_step)
  );

  dma_loop_ctr #(.NBW(NBW), .MJW(MJW)) i_loops (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load      (load_ok),
    .elem_done (elem_done),
    .nbytes    (cfg_load ? cfg_nbytes : nbytes_q),
    .nmajor    (cfg_load ? cfg_nmajor : nmajor_q),
    .elem_bytes(elem_bytes),
    .minor_last(minor_last),
    .major_last(major_last)
  );

  dma_req_count #(.PEND_W(PEND_W)) i_reqs (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .clear  (load_ok),
    .req    (req),
    .take   (minor_done),
    .has_req(has_req)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (has_req && desc_ok_q && !cfg_load) st_d = ST_READ;
      ST_READ:  if (mem_ready) st_d = ST_WRITE;
      ST_WRITE: if (mem_ready) st_d = minor_last ? ST_IDLE : ST_READ;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign addr_en = load_ok | elem_done;
  assign saddr_d = load_ok ? cfg_saddr : s_step;
  assign daddr_d = load_ok ? cfg_daddr : d_step;
  assign rbuf_en = (st_q == ST_READ) && mem_ready;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      st_q  <= ST_IDLE;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= major_done;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      saddr_q <= '0;
      daddr_q <= '0;
    end else if (addr_en) begin
      saddr_q <= saddr_d;
      daddr_q <= daddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) rbuf_q <= '0;
    else if (rbuf_en) rbuf_q <= mem_rdata;
  end

  assign mem_valid = (st_q != ST_IDLE);
  assign mem_write = (st_q == ST_WRITE);
  assign mem_addr  = mem_write ? daddr_q : saddr_q;
  assign mem_size  = size_q;
  assign mem_wdata = rbuf_q;
  assign irq       = irq_q;

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                   && $stable(mem_wdata))); // R9

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mem_valid && mem_ready && !mem_write) |=> (mem_valid && mem_write
                                                && (mem_wdata == $past(mem_rdata)))); // R3

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq |=> !irq); // R6

  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(irq) |-> $past(mem_valid && mem_write && mem_ready)); // R6

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    load_ok |=> (!mem_valid && (saddr_q == $past(cfg_saddr)))); // R10

endmodule

// File: tb/test_fifo_feed_dma.sv
module test_fifo_feed_dma;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RD_KEY = 32'h5A5A_C3C3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [31:0] cfg_saddr, cfg_daddr, cfg_slast, cfg_dlast;
  logic [15:0] cfg_soff, cfg_doff;
  logic [1:0]  cfg_size;
  logic [4:0]  cfg_smod, cfg_dmod;
  logic [9:0]  cfg_nbytes, cfg_nmajor;
  logic        req;
  logic        mem_valid, mem_write, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        irq;

  fifo_feed_dma i_fifo_feed_dma (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_saddr(cfg_saddr), .cfg_daddr(cfg_daddr),
    .cfg_soff(cfg_soff), .cfg_doff(cfg_doff), .cfg_size(cfg_size),
    .cfg_smod(cfg_smod), .cfg_dmod(cfg_dmod),
    .cfg_nbytes(cfg_nbytes), .cfg_nmajor(cfg_nmajor),
    .cfg_slast(cfg_slast), .cfg_dlast(cfg_dlast), .req(req),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_s, m_d, m_slast, m_dlast, m_rd;
  int m_soff, m_doff, m_smod, m_dmod, m_nbytes, m_nmajor, m_size;
  int m_bleft, m_mleft;
  bit m_wr_phase, m_fresh, irq_due, stall_on, run_model;
  int reqs, minors, irq_seen;
  bit prev_stall;
  logic [31:0] prev_addr;
  logic [7:0] lfsr = 8'hA7;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wrap_add(logic [31:0] a, int off, int m);
    logic [31:0] sum, keep;
    sum = a + 32'(off);
    if (m == 0) return sum;
    keep = 32'hFFFF_FFFF << m;
    return (a & keep) | (sum & ~keep);
  endfunction

  // per-cycle model and bus responder
  always @(negedge clk) begin
    if (run_model) begin
      bit rdy;
      check(irq === irq_due, "R6 irq timing", {31'd0, irq}, {31'd0, irq_due});
      if (irq) irq_seen++;
      irq_due = 0;
      if (reqs == minors) check(mem_valid === 1'b0, "R2 no access without request",
                                {31'd0, mem_valid}, 32'd0);
      if (prev_stall) check(mem_valid && mem_addr === prev_addr, "R9 hold on stall",
                            mem_addr, prev_addr);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy = mem_valid && (!stall_on || lfsr[0]);
      mem_ready = rdy;
      mem_rdata = mem_addr ^ RD_KEY;
      prev_stall = mem_valid && !rdy;
      prev_addr = mem_addr;
      if (rdy) begin
        check(mem_size === 2'(m_size), "R3 size code", {30'd0, mem_size}, 32'(m_size));
        if (!m_wr_phase) begin
          check(!mem_write, "R3 read first", {31'd0, mem_write}, 32'd0);
          check(mem_addr === m_s, m_fresh ? "R10 first read after load" :
                (m_smod != 0 ? "R5 source modulo address" : "R4 source address"),
                mem_addr, m_s);
          m_fresh = 0;
          m_rd = m_s ^ RD_KEY;
          m_wr_phase = 1;
        end else begin
          check(mem_write, "R3 write second", {31'd0, mem_write}, 32'd1);
          check(mem_addr === m_d, m_dmod != 0 ? "R5 dest modulo address" : "R4 dest address",
                mem_addr, m_d);
          check(mem_wdata === m_rd, "R3 write data", mem_wdata, m_rd);
          m_wr_phase = 0;
          m_s = wrap_add(m_s, m_soff, m_smod);
          m_d = wrap_add(m_d, m_doff, m_dmod);
          m_bleft -= (1 << m_size);
          if (m_bleft <= 0) begin
            minors++;
            m_bleft = m_nbytes;
            m_mleft--;
            if (m_mleft == 0) begin
              m_s += m_slast;
              m_d += m_dlast;
              m_mleft = m_nmajor;
              irq_due = 1;
            end
          end
        end
      end
    end else begin
      mem_ready = 0;
      mem_rdata = '0;
    end
  end

  task automatic load(logic [31:0] sa, logic [31:0] da, int so, int dof, int sz,
                      int sm, int dm, int nb, int nm, int sl, int dl);
    @(negedge clk);
    cfg_saddr = sa; cfg_daddr = da; cfg_soff = 16'(so); cfg_doff = 16'(dof);
    cfg_size = 2'(sz); cfg_smod = 5'(sm); cfg_dmod = 5'(dm);
    cfg_nbytes = 10'(nb); cfg_nmajor = 10'(nm);
    cfg_slast = 32'(sl); cfg_dlast = 32'(dl); cfg_load = 1;
    m_s = sa; m_d = da; m_soff = so; m_doff = dof; m_size = sz; m_smod = sm; m_dmod = dm;
    m_nbytes = nb; m_nmajor = nm; m_slast = 32'(sl); m_dlast = 32'(dl);
    m_bleft = nb; m_mleft = nm; m_wr_phase = 0; m_fresh = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic pulse_req(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req = 1; reqs++;
      @(negedge clk);
      req = 0;
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (reqs == minors && !mem_valid) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_load = 0; req = 0; run_model = 0; stall_on = 0;
    cfg_saddr = '0; cfg_daddr = '0; cfg_soff = '0; cfg_doff = '0; cfg_size = '0;
    cfg_smod = '0; cfg_dmod = '0; cfg_nbytes = '0; cfg_nmajor = '0;
    cfg_slast = '0; cfg_dlast = '0;
    reqs = 0; minors = 0; irq_seen = 0; irq_due = 0; prev_stall = 0;
    repeat (3) @(negedge clk);
    check(mem_valid === 1'b0 && irq === 1'b0, "R1 reset outputs",
          {30'd0, mem_valid, irq}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(mem_valid === 1'b0 && irq === 1'b0, "R1 idle after reset",
          {30'd0, mem_valid, irq}, 32'd0);
    run_model = 1;

    // word source walking a 32-byte window from its middle, fixed FIFO destination
    load(32'h0000_1010, 32'h8000_0040, 4, 0, 2, 5, 0, 16, 2, 0, 0);
    for (int k = 0; k < 6; k++) begin
      pulse_req(1);
      drain();
    end
    check(irq_seen == 3, "R7 three majors back to back", 32'(irq_seen), 32'd3);
    check(minors == 6, "R2 one minor per request", 32'(minors), 32'd6);

    // halfwords, negative source step, destination window, end adjustments, stalls
    stall_on = 1;
    load(32'h0000_4000, 32'h0000_200C, -2, 2, 1, 0, 4, 4, 2, 8, -16);
    pulse_req(1);
    @(negedge clk); req = 1; reqs++;
    @(negedge clk); req = 1; reqs++;
    @(negedge clk); req = 1; reqs++;
    @(negedge clk); req = 0;
    drain();
    check(minors == reqs, "R8 burst requests all served", 32'(minors), 32'(reqs));
    check(irq_seen == 5, "R6 interrupt count", 32'(irq_seen), 32'd5);

    // single byte, one minor per major: interrupt on each request
    load(32'h0000_0300, 32'h0000_0500, 1, 0, 0, 0, 0, 3, 1, 0, 0);
    pulse_req(2);
    drain();
    check(irq_seen == 7, "R6 interrupt every request", 32'(irq_seen), 32'd7);
    check(minors == reqs, "R8 all requests served", 32'(minors), 32'(reqs));

    finish_run();
  end

endmodule